// File: doc/BRIEF.md
# Debug System Bus Access Bridge

This block gives an external debugger a path onto a system bus through three registers: a control/status word, an address word and a data word. The debugger writes and reads them over a plain register port. Each bus transaction is a side effect of a register access. Writing the data word issues a bus write. Writing the address word issues a bus read when read-on-address mode is on. Reading the data word issues a bus read when read-on-data mode is on. Each transaction is one beat on a request/done bus. The request stays high until the bus answers with done, and the bus may flag an error at the same moment.

The access size is selected by a code. The bus is 32 bits wide, so only the 8, 16 and 32-bit sizes are legal, and capability bits in the control word report this. Autoincrement steps the address by the access width after each successful access. A bus failure and an illegal size are each reported by a sticky error code. A second sticky flag records any address or data write made while a transaction is still open. Both are cleared by writing 1, and while either is set no new transaction starts.

Top module: `sba_bridge`

## Requirements
- R1: After reset the control word reads 0x2000_3800. The version field in bits [31:29] is 1, capability bits 11, 12 and 13 (8, 16 and 32 bits) are 1, bits 14 and 15 (64 and 128 bits) are 0, and every other field is 0. bus_req is low.
- R2: Register selects are 0 for control, 1 for address and 2 for data. Control bits [2:0] hold the size code (0 = 8, 1 = 16, 2 = 32, 3 = 64, 4 = 128 bits). A data write with no fault pending starts a bus write to the address word, with bus_size equal to the size code and bus_wdata equal to the data masked to the access width.
- R3: When control bit 4 (read-on-address) is set, an address write starts a bus read at the new address. On done the data word takes bus_rdata zero-extended from the access width.
- R4: When control bit 5 (read-on-data) is set, a data read returns the value held before the read and then starts a bus read at the current address.
- R5: When control bit 3 (autoincrement) is set, the address word grows by 2^size after each access that ends without a bus error. It is unchanged after a bus error, and it never changes when bit 3 is clear.
- R6: Control bit 10 (busy) is high from the cycle after a start until the edge where done is sampled. bus_req is held through the same span.
- R7: A transaction that ends with bus_err high sets the error field in control bits [8:6] to 2.
- R8: A start attempted with a size code above 2 sets the error field to 3 and issues no bus transaction.
- R9: A control write with any 1 in bits [8:6] clears the error field, and a control write with bit 9 set clears the busy-error flag. Writing 0 there leaves them unchanged.
- R10: An address or data write made while busy sets control bit 9 (busy-error), is otherwise ignored, and leaves the address word unchanged.
- R11: While the error field is nonzero or the busy-error flag is set, no access that would otherwise start reaches the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; triggers read-on-data |
| reg_rdata | output | 32 | Selected register value |
| bus_req | output | 1 | Transaction request, held until done |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Transaction address |
| bus_size | output | 3 | Access size code |
| bus_wdata | output | 32 | Write data, masked to the access width |
| bus_rdata | input | 32 | Read data, valid with done |
| bus_done | input | 1 | Transaction completion |
| bus_err | input | 1 | Transaction rejected, valid with done |

## Verification
A triggering register access at a given clock edge raises bus_req and busy right after that edge. The bench's monitor therefore checks each transaction against the expected queue at the following falling edge. A result such as new read data, an autoincremented address or an error code appears right after the edge where done is sampled, so the bench polls the busy bit until it falls and only then reads the registers. Size faults and busy violations update the control word right after the offending write, and the control word is read in the next cycle.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int NUM_SIZES  = 5;
  localparam int B_SIZE     = 0;
  localparam int B_AUTOINC  = 3;
  localparam int B_RONA     = 4;
  localparam int B_ROND     = 5;
  localparam int B_ERR      = 6;
  localparam int B_BERR     = 9;
  localparam int B_BUSY     = 10;
  localparam int B_CAP      = 11;
  localparam int B_VER      = 29;

  localparam logic [2:0] ERR_NONE = 3'd0;
  localparam logic [2:0] ERR_BUS  = 3'd2;
  localparam logic [2:0] ERR_SIZE = 3'd3;
  localparam logic [2:0] VERSION  = 3'd1;
endpackage

// File: rtl/sba_rst_sync.sv
module sba_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sba_size_unit.sv
module sba_size_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic [2:0]                   req_size,
  input  logic [2:0]                   act_size,
  output logic                         size_ok,
  output logic [sba_pkg::NUM_SIZES-1:0] caps,
  output logic [DATA_W-1:0]            lane_mask,
  output logic [ADDR_W-1:0]            step
);
  localparam int MAX_SIZE = $clog2(DATA_W / 8);

  for (genvar i = 0; i < sba_pkg::NUM_SIZES; i++) begin : g_cap
    assign caps[i] = (i <= MAX_SIZE);
  end

  assign size_ok = (int'(req_size) <= MAX_SIZE);

  always_comb begin
    lane_mask = '0;
    for (int s = 0; s <= MAX_SIZE; s++) begin
      if (int'(act_size) == s) begin
        for (int b = 0; b < DATA_W; b++) begin
          lane_mask[b] = (b < (8 << s));
        end
      end
    end
  end

  assign step = ADDR_W'(1) << act_size;
endmodule

// File: rtl/sba_engine.sv
module sba_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_we,
  input  logic [2:0] start_size,
  input  logic       bus_done,
  input  logic       bus_err,
  output logic       busy,
  output logic       act_we,
  output logic [2:0] act_size,
  output logic       cmpl,
  output logic       cmpl_err
);
  logic       req_q, req_n;
  logic       we_q, we_n;
  logic [2:0] size_q, size_n;
  logic       load_en;

  assign cmpl     = req_q & bus_done;
  assign cmpl_err = cmpl & bus_err;
  assign load_en  = start & ~req_q;

  always_comb begin
    req_n  = req_q;
    we_n   = we_q;
    size_n = size_q;
    if (load_en) begin
      req_n  = 1'b1;
      we_n   = start_we;
      size_n = start_size;
    end else if (cmpl) begin
      req_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      size_q <= 3'd0;
    end else begin
      req_q <= req_n;
      if (load_en) begin
        we_q   <= we_n;
        size_q <= size_n;
      end
    end
  end

  assign busy     = req_q;
  assign act_we   = we_q;
  assign act_size = size_q;
endmodule

// File: rtl/sba_regs.sv
module sba_regs #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    reg_sel,
  input  logic [DATA_W-1:0]             reg_wdata,
  input  logic                          reg_we,
  input  logic                          reg_re,
  output logic [DATA_W-1:0]             reg_rdata,
  input  logic                          busy,
  input  logic                          cmpl,
  input  logic                          cmpl_err,
  input  logic                          act_we,
  input  logic [DATA_W-1:0]             rdata_in,
  input  logic [ADDR_W-1:0]             step,
  input  logic                          size_ok,
  input  logic [sba_pkg::NUM_SIZES-1:0] caps,
  output logic [2:0]                    size_code,
  output logic                          start,
  output logic                          start_we,
  output logic [ADDR_W-1:0]             addr_q,
  output logic [DATA_W-1:0]             data_q,
  output logic [2:0]                    err_code,
  output logic                          busy_err
);
  import sba_pkg::*;

  logic [2:0]        size_q, size_n;
  logic              autoinc_q, autoinc_n;
  logic              rona_q, rona_n;
  logic              rond_q, rond_n;
  logic [2:0]        err_q, err_n;
  logic              berr_q, berr_n;
  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] data_n;

  logic wr_ctrl, wr_addr, wr_data, rd_data;
  logic trig_wr, trig_rd, trig_any, touch, blocked, size_fault, good_cmpl;

  assign wr_ctrl = reg_we & (reg_sel == SEL_CTRL);
  assign wr_addr = reg_we & (reg_sel == SEL_ADDR);
  assign wr_data = reg_we & (reg_sel == SEL_DATA);
  assign rd_data = reg_re & (reg_sel == SEL_DATA);

  assign trig_wr    = wr_data;
  assign trig_rd    = (wr_addr & rona_q) | (rd_data & rond_q);
  assign trig_any   = trig_wr | trig_rd;
  assign touch      = wr_addr | wr_data;
  assign blocked    = (err_q != ERR_NONE) | berr_q;
  assign start      = trig_any & ~busy & ~blocked & size_ok;
  assign start_we   = trig_wr;
  assign size_fault = trig_any & ~busy & ~blocked & ~size_ok;
  assign good_cmpl  = cmpl & ~cmpl_err;

  always_comb begin
    size_n    = size_q;
    autoinc_n = autoinc_q;
    rona_n    = rona_q;
    rond_n    = rond_q;
    if (wr_ctrl) begin
      size_n    = reg_wdata[B_SIZE +: 3];
      autoinc_n = reg_wdata[B_AUTOINC];
      rona_n    = reg_wdata[B_RONA];
      rond_n    = reg_wdata[B_ROND];
    end
  end

  always_comb begin
    addr_n = addr_q;
    if (wr_addr && !busy)             addr_n = reg_wdata[ADDR_W-1:0];
    else if (good_cmpl && autoinc_q)  addr_n = addr_q + step;
  end

  always_comb begin
    data_n = data_q;
    if (wr_data && !busy)             data_n = reg_wdata;
    else if (good_cmpl && !act_we)    data_n = rdata_in;
  end

  always_comb begin
    err_n = err_q;
    if (cmpl_err)                              err_n = ERR_BUS;
    else if (size_fault)                       err_n = ERR_SIZE;
    else if (wr_ctrl && |reg_wdata[B_ERR +: 3]) err_n = ERR_NONE;
  end

  always_comb begin
    berr_n = berr_q;
    if (touch && busy)                  berr_n = 1'b1;
    else if (wr_ctrl && reg_wdata[B_BERR]) berr_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q    <= 3'd0;
      autoinc_q <= 1'b0;
      rona_q    <= 1'b0;
      rond_q    <= 1'b0;
      err_q     <= ERR_NONE;
      berr_q    <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        size_q    <= size_n;
        autoinc_q <= autoinc_n;
        rona_q    <= rona_n;
        rond_q    <= rond_n;
      end
      err_q  <= err_n;
      berr_q <= berr_n;
      addr_q <= addr_n;
      data_q <= data_n;
    end
  end

  logic [DATA_W-1:0] ctrl_word;
  always_comb begin
    ctrl_word                 = '0;
    ctrl_word[B_SIZE +: 3]    = size_q;
    ctrl_word[B_AUTOINC]      = autoinc_q;
    ctrl_word[B_RONA]         = rona_q;
    ctrl_word[B_ROND]         = rond_q;
    ctrl_word[B_ERR +: 3]     = err_q;
    ctrl_word[B_BERR]         = berr_q;
    ctrl_word[B_BUSY]         = busy;
    ctrl_word[B_CAP +: NUM_SIZES] = caps;
    ctrl_word[B_VER +: 3]     = VERSION;
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = ctrl_word;
      SEL_ADDR: reg_rdata = DATA_W'(addr_q);
      SEL_DATA: reg_rdata = data_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign size_code = size_q;
  assign err_code  = err_q;
  assign busy_err  = berr_q;
endmodule

// File: rtl/sba_bridge.sv
module sba_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [2:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_done,
  input  logic              bus_err
);
  logic                          rst_n_int;
  logic                          busy, act_we, cmpl, cmpl_err;
  logic [2:0]                    act_size, size_code, err_code;
  logic                          start, start_we, size_ok, busy_err;
  logic [sba_pkg::NUM_SIZES-1:0] caps;
  logic [DATA_W-1:0]             lane_mask, data_q;
  logic [ADDR_W-1:0]             step, addr_q;

  sba_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sba_size_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_size (
    .req_size  (size_code),
    .act_size  (act_size),
    .size_ok   (size_ok),
    .caps      (caps),
    .lane_mask (lane_mask),
    .step      (step)
  );

  sba_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start      (start),
    .start_we   (start_we),
    .start_size (size_code),
    .bus_done   (bus_done),
    .bus_err    (bus_err),
    .busy       (busy),
    .act_we     (act_we),
    .act_size   (act_size),
    .cmpl       (cmpl),
    .cmpl_err   (cmpl_err)
  );

  sba_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .cmpl      (cmpl),
    .cmpl_err  (cmpl_err),
    .act_we    (act_we),
    .rdata_in  (bus_rdata & lane_mask),
    .step      (step),
    .size_ok   (size_ok),
    .caps      (caps),
    .size_code (size_code),
    .start     (start),
    .start_we  (start_we),
    .addr_q    (addr_q),
    .data_q    (data_q),
    .err_code  (err_code),
    .busy_err  (busy_err)
  );

  assign bus_req   = busy;
  assign bus_we    = act_we;
  assign bus_addr  = addr_q;
  assign bus_size  = act_size;
  assign bus_wdata = data_q & lane_mask;
endmodule

// File: rtl/sba_bridge_chk.sv
module sba_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_done,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [2:0]        bus_size,
  input logic [2:0]        err_code,
  input logic              busy_err,
  input logic [1:0]        reg_sel,
  input logic [DATA_W-1:0] reg_rdata
);
  localparam int MAX_SIZE = $clog2(DATA_W / 8);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> bus_req);

  assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_done) |=> !bus_req);

  assert_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> ($stable(bus_addr) && $stable(bus_size) && $stable(bus_we)));

  assert_legal_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (int'(bus_size) <= MAX_SIZE));

  assert_clean_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> ($past(err_code) == 3'd0 && !$past(busy_err)));

  assert_version_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> (reg_rdata[31:29] == 3'd1));
endmodule

bind sba_bridge sba_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_done  (bus_done),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .err_code  (err_code),
  .busy_err  (busy_err),
  .reg_sel   (reg_sel),
  .reg_rdata (reg_rdata)
);

// File: tb/sim_sba_bridge.sv
module sim_sba_bridge;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] S_CTRL = 2'd0, S_ADDR = 2'd1, S_DATA = 2'd2;

  logic        clk, rst_n;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_we, reg_re;
  logic        bus_req, bus_we, bus_done, bus_err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [2:0]  bus_size;

  int n_chk = 0;
  int n_err = 0;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [2:0]  size;
    logic [31:0] wdata;
  } txn_t;
  txn_t exp_q[$];

  sba_bridge u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done), .bus_err(bus_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[31:16] ^ 16'hC3C3};
  endfunction

  function automatic logic [31:0] width_mask(input logic [2:0] s);
    case (s)
      3'd0:    return 32'h0000_00FF;
      3'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // bus responder: done three cycles into a request, error on top nibble F
  logic [3:0] lat;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= 4'd0; bus_done <= 1'b0;
    end else begin
      bus_done <= 1'b0;
      if (bus_req && !bus_done) begin
        if (lat == 4'd2) begin bus_done <= 1'b1; lat <= 4'd0; end
        else lat <= lat + 4'd1;
      end
    end
  end
  assign bus_rdata = bus_done ? mem_fn(bus_addr) : 32'h0;
  assign bus_err   = bus_done && (bus_addr[31:28] == 4'hF);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_re = 1'b1; #1;
    d = reg_rdata;
    @(posedge clk); #1;
    reg_re = 1'b0;
  endtask

  task automatic expect_bus(input logic we, input logic [31:0] a, input logic [2:0] s,
                            input logic [31:0] d);
    txn_t t;
    t.we = we; t.addr = a; t.size = s; t.wdata = we ? (d & width_mask(s)) : 32'h0;
    exp_q.push_back(t);
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    bit done_ok = 0;
    for (int i = 0; i < 40; i++) begin
      rd(S_CTRL, v);
      if (!v[10]) begin done_ok = 1; break; end
    end
    if (!done_ok) begin
      n_chk++; n_err++;
      $display("FAIL %s busy stuck actual=1 expected=0", tag);
    end
  endtask

  // monitor: compare each new request against the scoreboard queue
  logic prev_req = 1'b0;
  always @(negedge clk) begin
    if (rst_n && bus_req && !prev_req) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R11 unexpected bus access actual=%h expected=none", bus_addr);
      end else begin
        txn_t e, a;
        e = exp_q.pop_front();
        a.we = bus_we; a.addr = bus_addr; a.size = bus_size;
        a.wdata = bus_we ? bus_wdata : 32'h0;
        if (a !== e) begin
          n_err++;
          $display("FAIL R2 R3 bus txn actual=%h expected=%h", a, e);
        end
      end
    end
    prev_req = bus_req;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_sel = S_CTRL; reg_wdata = '0; reg_we = 1'b0; reg_re = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    rd(S_CTRL, v); check("R1 ctrl reset", v, 32'h2000_3800);
    check("R1 bus_req reset", {31'h0, bus_req}, 32'h0);
    rd(S_ADDR, v); check("R1 addr reset", v, 32'h0);

    // R2 writes at size 2 and size 0, no autoincrement
    wr(S_CTRL, 32'd2);
    wr(S_ADDR, 32'h1000_0010);
    expect_bus(1'b1, 32'h1000_0010, 3'd2, 32'hCAFE_BABE);
    wr(S_DATA, 32'hCAFE_BABE);
    wait_idle("R2");
    rd(S_ADDR, v); check("R5 no autoinc", v, 32'h1000_0010);
    wr(S_CTRL, 32'd0);
    expect_bus(1'b1, 32'h1000_0010, 3'd0, 32'h1234_56AB);
    wr(S_DATA, 32'h1234_56AB);
    wait_idle("R2 byte");

    // R3 read on address, 32 and 16 bit
    wr(S_CTRL, 32'd2 | 32'h10);
    expect_bus(1'b0, 32'h2000_0040, 3'd2, 0);
    wr(S_ADDR, 32'h2000_0040);
    wait_idle("R3");
    rd(S_DATA, v); check("R3 read word", v, mem_fn(32'h2000_0040));
    wr(S_CTRL, 32'd1 | 32'h10);
    expect_bus(1'b0, 32'h2000_0042, 3'd1, 0);
    wr(S_ADDR, 32'h2000_0042);
    wait_idle("R3 half");
    rd(S_DATA, v); check("R3 zero extend", v, mem_fn(32'h2000_0042) & 32'hFFFF);

    // R5 autoincrement across writes
    wr(S_CTRL, 32'd2 | 32'h08);
    wr(S_ADDR, 32'h3000_0000);
    for (int i = 0; i < 3; i++) begin
      expect_bus(1'b1, 32'h3000_0000 + 32'(4 * i), 3'd2, 32'h100 + 32'(i));
      wr(S_DATA, 32'h100 + 32'(i));
      wait_idle("R5 loop");
    end
    rd(S_ADDR, v); check("R5 step 4", v, 32'h3000_000C);
    wr(S_CTRL, 32'd0 | 32'h08);
    expect_bus(1'b1, 32'h3000_000C, 3'd0, 32'h55);
    wr(S_DATA, 32'h55);
    wait_idle("R5 byte");
    rd(S_ADDR, v); check("R5 step 1", v, 32'h3000_000D);

    // R4 read on data
    wr(S_CTRL, 32'd2 | 32'h08 | 32'h20);
    wr(S_ADDR, 32'h4000_0000);
    expect_bus(1'b0, 32'h4000_0000, 3'd2, 0);
    rd(S_DATA, v);
    wait_idle("R4 first");
    expect_bus(1'b0, 32'h4000_0004, 3'd2, 0);
    rd(S_DATA, v); check("R4 held value", v, mem_fn(32'h4000_0000));
    wait_idle("R4 second");
    wr(S_CTRL, 32'd2 | 32'h08);
    rd(S_DATA, v); check("R4 next value", v, mem_fn(32'h4000_0004));
    rd(S_ADDR, v); check("R5 read autoinc", v, 32'h4000_0008);

    // R6 busy, R10 busy violation, R11 blocking, R9 clear
    wr(S_CTRL, 32'd2 | 32'h10);
    expect_bus(1'b0, 32'h2000_0100, 3'd2, 0);
    wr(S_ADDR, 32'h2000_0100);
    rd(S_CTRL, v); check("R6 busy high", {31'h0, v[10]}, 32'h1);
    wr(S_ADDR, 32'h2000_0200);
    wait_idle("R6");
    rd(S_CTRL, v); check("R10 busy error", {31'h0, v[9]}, 32'h1);
    rd(S_ADDR, v); check("R10 addr kept", v, 32'h2000_0100);
    wr(S_DATA, 32'h77);
    repeat (6) @(negedge clk);
    wr(S_CTRL, 32'd2);
    rd(S_CTRL, v); check("R9 zero keeps busy error", {31'h0, v[9]}, 32'h1);
    wr(S_CTRL, 32'd2 | 32'h200);
    rd(S_CTRL, v); check("R9 busy error cleared", {31'h0, v[9]}, 32'h0);

    // R7 bus error
    wr(S_CTRL, 32'd2 | 32'h08);
    wr(S_ADDR, 32'hF000_0000);
    expect_bus(1'b1, 32'hF000_0000, 3'd2, 32'h1);
    wr(S_DATA, 32'h1);
    wait_idle("R7");
    rd(S_CTRL, v); check("R7 err code", {29'h0, v[8:6]}, 32'd2);
    rd(S_ADDR, v); check("R5 no step on error", v, 32'hF000_0000);
    wr(S_DATA, 32'h2);
    repeat (6) @(negedge clk);
    wr(S_CTRL, 32'd2 | 32'h08);
    rd(S_CTRL, v); check("R9 zero keeps err", {29'h0, v[8:6]}, 32'd2);
    wr(S_CTRL, 32'd2 | 32'h40);
    rd(S_CTRL, v); check("R9 err cleared", {29'h0, v[8:6]}, 32'd0);

    // R8 unsupported sizes
    wr(S_ADDR, 32'h1000_0000);
    wr(S_CTRL, 32'd3);
    wr(S_DATA, 32'h9);
    rd(S_CTRL, v); check("R8 size 3", {29'h0, v[8:6]}, 32'd3);
    wr(S_CTRL, 32'd4 | 32'h80);
    wr(S_DATA, 32'h9);
    rd(S_CTRL, v); check("R8 size 4", {29'h0, v[8:6]}, 32'd3);
    wr(S_CTRL, 32'd2 | 32'h40);
    rd(S_CTRL, v); check("R9 clear size err", v, 32'h2000_3802);

    repeat (8) @(negedge clk);
    check("R11 R8 queue drained", 32'(exp_q.size()), 32'd0);
    report();
    $finish;
  end
endmodule